// File: doc/BRIEF.md
# Conditional Search Qualifier Register Bank

This block sits beside the command decoder of a two-channel I/O device on a single-wire bus. It holds the three registers that decide whether the device answers a conditional search. These are a channel select mask, a per-channel polarity register and a control/status register. From them, and from the live channel inputs, it drives one combinational `respond` flag that the search logic samples.

Each channel draws its condition bit from one of two sources: its pin level or its activity latch. A channel hits when that bit equals its polarity bit. The selected hits are then merged by OR or by AND. A power-on latch overrides the merge and forces `respond` high until software clears it. The latch is a two-state machine. `PORL_SET` is entered at reset. The transition `clear_by_write` moves it to `PORL_CLEAR` on a control write whose bit 3 is 0. `PORL_CLEAR` has one transition, `hold_clear`, back to itself, and only reset returns the machine to `PORL_SET`.

The control/status register also shows two live status inputs. One is the polarity strap, which sets the power-up level of the channel pins. The other is the supply-present flag.

Top module: `csq_bank`

## Requirements
- R1: After reset the mask (address 0x223) and the polarity register (0x224) read 0x00. The control/status register (0x225) reads 0x08 ORed with the live status bits, with PLS (bit 0) at 0, CT (bit 1) at 0 and PORL (bit 3) at 1.
- R2: The mask and polarity registers store only bits 1:0, one bit per channel with channel 0 in bit 0. Bits 7:2 read 0 whatever was written.
- R3: Control/status bits 2, 4 and 5 always read 0. Bit 6 always shows `strap_pol` and bit 7 always shows `supply_ok`, both live. Writes to bits 6 and 7 have no effect.
- R4: A write to 0x225 with bit 3 at 0 clears PORL. A write with bit 3 at 1 leaves PORL unchanged. Once cleared, PORL stays 0 until reset.
- R5: While PORL is 1, `respond` is 1 for every register and input value.
- R6: With PLS at 0 each channel's condition bit is its `pio_pin` bit. With PLS at 1 it is its `pio_act` bit. A channel hits when that bit equals its polarity bit.
- R7: With CT at 0 and PORL at 0, `respond` is 1 when at least one selected channel hits.
- R8: With CT at 1 and PORL at 0, `respond` is 1 when every selected channel hits. With a single channel selected, CT makes no difference.
- R9: With no channel selected and PORL at 0, `respond` is 0.
- R10: `respond` follows a change of `pio_pin` or `pio_act` in the same cycle, with no clock edge in between.
- R11: Reads from any address other than 0x223 to 0x225 return 0. Writes to such addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, power-on |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 10 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 10 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| pio_pin | input | 2 | Channel pin levels |
| pio_act | input | 2 | Channel activity-latch bits |
| strap_pol | input | 1 | Polarity strap pin level |
| supply_ok | input | 1 | Supply power present |
| respond | output | 1 | Take part in conditional search |

## Verification
The qualifier is swept over every mask, polarity, source select, combine term and pair of pin and latch levels, with PORL cleared. The empty mask isolates the idle case. The single-channel masks show that CT does not matter. The two-channel mask separates OR from AND. Flipping the unused source shows that the source select really picks one input. A second pass with PORL still set shows that the latch overrides every pattern, and writes of all-ones and zero patterns tell masked, read-only and sticky bits apart.

// File: rtl/csq_pkg.sv
`timescale 1ns/1ps
package csq_pkg;
    localparam int SRC_BIT    = 0;
    localparam int CT_BIT     = 1;
    localparam int PORL_BIT   = 3;
    localparam int STRAP_BIT  = 6;
    localparam int SUPPLY_BIT = 7;

    typedef enum logic [0:0] {
        PORL_SET   = 1'b0,
        PORL_CLEAR = 1'b1
    } porl_state_t;
endpackage

// File: rtl/csq_regfile.sv
`timescale 1ns/1ps
module csq_regfile #(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 8,
    parameter int NCH       = 2,
    parameter int MASK_ADDR = 'h223,
    parameter int POL_ADDR  = 'h224,
    parameter int CTRL_ADDR = 'h225
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [NCH-1:0]    mask_q,
    output logic [NCH-1:0]    pol_q,
    output logic              src_q,
    output logic              ct_q,
    output logic              ctrl_wr,
    output logic              ctrl_porl_bit
);
    import csq_pkg::*;

    logic hit_mask, hit_pol, hit_ctrl;
    logic [DATA_W-1:0] unused_data;

    assign hit_mask = wr_en && (wr_addr == ADDR_W'(MASK_ADDR));
    assign hit_pol  = wr_en && (wr_addr == ADDR_W'(POL_ADDR));
    assign hit_ctrl = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));

    assign ctrl_wr       = hit_ctrl;
    assign ctrl_porl_bit = wr_data[PORL_BIT];
    assign unused_data   = wr_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            pol_q  <= '0;
            src_q  <= 1'b0;
            ct_q   <= 1'b0;
        end else begin
            if (hit_mask) mask_q <= wr_data[NCH-1:0];
            if (hit_pol)  pol_q  <= wr_data[NCH-1:0];
            if (hit_ctrl) begin
                src_q <= wr_data[SRC_BIT];
                ct_q  <= wr_data[CT_BIT];
            end
        end
    end
endmodule

// File: rtl/csq_porl_fsm.sv
`timescale 1ns/1ps
module csq_porl_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic ctrl_porl_bit,
    output logic porl
);
    import csq_pkg::*;

    porl_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PORL_SET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        porl    = 1'b0;
        unique case (state_q)
            PORL_SET: begin
                porl = 1'b1;
                if (ctrl_wr && !ctrl_porl_bit) state_d = PORL_CLEAR;
            end
            PORL_CLEAR: begin
                porl    = 1'b0;
                state_d = PORL_CLEAR;
            end
            default: begin
                porl    = 1'b1;
                state_d = PORL_SET;
            end
        endcase
    end
endmodule

// File: rtl/csq_match.sv
`timescale 1ns/1ps
module csq_match #(
    parameter int NCH = 2
) (
    input  logic [NCH-1:0] mask,
    input  logic [NCH-1:0] pol,
    input  logic           src_sel,
    input  logic           ct,
    input  logic           porl,
    input  logic [NCH-1:0] pin,
    input  logic [NCH-1:0] act,
    output logic           respond
);
    logic [NCH-1:0] hit, or_term, and_term;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic level;
        assign level        = src_sel ? act[ch] : pin[ch];
        assign hit[ch]      = (level == pol[ch]);
        assign or_term[ch]  = mask[ch] & hit[ch];
        assign and_term[ch] = ~mask[ch] | hit[ch];
    end

    always_comb begin
        if (porl)            respond = 1'b1;
        else if (mask == '0) respond = 1'b0;
        else if (ct)         respond = &and_term;
        else                 respond = |or_term;
    end
endmodule

// File: rtl/csq_bank.sv
`timescale 1ns/1ps
module csq_bank #(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 8,
    parameter int NCH       = 2,
    parameter int MASK_ADDR = 'h223,
    parameter int POL_ADDR  = 'h224,
    parameter int CTRL_ADDR = 'h225
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [NCH-1:0]    pio_pin,
    input  logic [NCH-1:0]    pio_act,
    input  logic              strap_pol,
    input  logic              supply_ok,
    output logic              respond
);
    import csq_pkg::*;

    logic [NCH-1:0] mask_q, pol_q;
    logic src_q, ct_q, ctrl_wr, ctrl_porl_bit, porl_q;

    csq_regfile #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCH(NCH),
        .MASK_ADDR(MASK_ADDR), .POL_ADDR(POL_ADDR), .CTRL_ADDR(CTRL_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mask_q(mask_q), .pol_q(pol_q), .src_q(src_q),
        .ct_q(ct_q), .ctrl_wr(ctrl_wr), .ctrl_porl_bit(ctrl_porl_bit)
    );

    csq_porl_fsm u_porl (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
        .ctrl_porl_bit(ctrl_porl_bit), .porl(porl_q)
    );

    csq_match #(.NCH(NCH)) u_match (
        .mask(mask_q), .pol(pol_q), .src_sel(src_q), .ct(ct_q),
        .porl(porl_q), .pin(pio_pin), .act(pio_act), .respond(respond)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(MASK_ADDR)) begin
            rd_data[NCH-1:0] = mask_q;
        end else if (rd_addr == ADDR_W'(POL_ADDR)) begin
            rd_data[NCH-1:0] = pol_q;
        end else if (rd_addr == ADDR_W'(CTRL_ADDR)) begin
            rd_data[SRC_BIT]    = src_q;
            rd_data[CT_BIT]     = ct_q;
            rd_data[PORL_BIT]   = porl_q;
            rd_data[STRAP_BIT]  = strap_pol;
            rd_data[SUPPLY_BIT] = supply_ok;
        end
    end
endmodule

// File: rtl/csq_bank_chk.sv
`timescale 1ns/1ps
module csq_bank_chk #(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 8,
    parameter int NCH       = 2,
    parameter int MASK_ADDR = 'h223,
    parameter int POL_ADDR  = 'h224,
    parameter int CTRL_ADDR = 'h225
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              strap_pol,
    input logic              supply_ok,
    input logic              respond,
    input logic              porl,
    input logic [NCH-1:0]    mask
);
    // R5
    porl_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        porl |-> respond);

    // R4
    porl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(CTRL_ADDR) && !wr_data[3]) |=> !porl);

    // R4
    porl_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !porl |=> !porl);

    // R9
    idle_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!porl && mask == '0) |-> !respond);

    // R3
    status_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_W'(CTRL_ADDR)) |->
            (rd_data[7] == supply_ok && rd_data[6] == strap_pol &&
             rd_data[5:4] == 2'b00 && rd_data[2] == 1'b0));

    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_W'(MASK_ADDR) || rd_addr == ADDR_W'(POL_ADDR)) |->
            (rd_data[DATA_W-1:NCH] == '0));
endmodule

bind csq_bank csq_bank_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCH(NCH),
    .MASK_ADDR(MASK_ADDR), .POL_ADDR(POL_ADDR), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .strap_pol(strap_pol), .supply_ok(supply_ok), .respond(respond),
    .porl(porl_q), .mask(mask_q)
);

// File: tb/csq_bank_test.sv
`timescale 1ns/1ps
module csq_bank_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [9:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [9:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [1:0] pio_pin = '0;
    logic [1:0] pio_act = '0;
    logic       strap_pol = 1'b1;
    logic       supply_ok = 1'b0;
    logic       respond;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    csq_bank uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pio_pin(pio_pin), .pio_act(pio_act), .strap_pol(strap_pol),
        .supply_ok(supply_ok), .respond(respond)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [9:0] a, input logic [7:0] exp);
        rd_addr = a;
        #0.5;
        check(tag, rd_data, exp);
    endtask

    function automatic logic model(input logic porl, input logic [1:0] m, input logic [1:0] p,
                                   input logic pls, input logic ct,
                                   input logic [1:0] pin, input logic [1:0] act);
        logic [1:0] src, hit;
        src = pls ? act : pin;
        hit = ~(src ^ p);
        if (porl) return 1'b1;
        if (m == 2'b00) return 1'b0;
        if (ct) return &(~m | hit);
        return |(m & hit);
    endfunction

    task automatic sweep(input logic porl);
        for (int cfg = 0; cfg < 64; cfg++) begin
            logic [1:0] m, p;
            logic pls, ct;
            m = cfg[1:0]; p = cfg[3:2]; pls = cfg[4]; ct = cfg[5];
            wr(10'h223, {6'b0, m});
            wr(10'h224, {6'b0, p});
            wr(10'h225, {6'b0, porl, 1'b0, ct, pls});
            for (int io = 0; io < 16; io++) begin
                pio_pin = io[1:0];
                pio_act = io[3:2];
                #0.5;
                if (porl)
                    check("R5 forced respond", {7'b0, respond}, 8'h01);
                else if (m == 2'b00)
                    check("R9 empty mask", {7'b0, respond}, 8'h00);
                else if (ct)
                    check("R6 R8 and-combine", {7'b0, respond},
                          {7'b0, model(1'b0, m, p, pls, ct, pin_v(io), act_v(io))});
                else
                    check("R6 R7 or-combine", {7'b0, respond},
                          {7'b0, model(1'b0, m, p, pls, ct, pin_v(io), act_v(io))});
            end
        end
    endtask

    function automatic logic [1:0] pin_v(input int io); return io[1:0]; endfunction
    function automatic logic [1:0] act_v(input int io); return io[3:2]; endfunction

    initial begin
        #(200000 * 4);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values (strap=1, supply=0)
        rd_check("R1 mask reset", 10'h223, 8'h00);
        rd_check("R1 pol reset", 10'h224, 8'h00);
        rd_check("R1 ctrl reset", 10'h225, 8'h48);
        check("R1 respond after reset", {7'b0, respond}, 8'h01);

        // R3 live status bits
        strap_pol = 1'b0; supply_ok = 1'b1;
        rd_check("R3 live status", 10'h225, 8'h88);
        wr(10'h225, 8'hFF);
        rd_check("R3 R4 ctrl after ones", 10'h225, 8'h8B);

        // R2 masking of upper bits
        wr(10'h223, 8'hFF);
        rd_check("R2 mask upper", 10'h223, 8'h03);
        wr(10'h224, 8'hFE);
        rd_check("R2 pol upper", 10'h224, 8'h02);

        // R11 unmapped address
        wr(10'h226, 8'hFF);
        wr(10'h222, 8'h00);
        rd_check("R11 unmapped read", 10'h226, 8'h00);
        rd_check("R11 mask untouched", 10'h223, 8'h03);
        rd_check("R11 ctrl untouched", 10'h225, 8'h8B);

        // R5 porl forces respond across all patterns
        sweep(1'b1);

        // R4 clear then try to set
        wr(10'h225, 8'h00);
        rd_check("R4 porl cleared", 10'h225, 8'h80);
        wr(10'h225, 8'h08);
        rd_check("R4 porl stays clear", 10'h225, 8'h80);

        // R6 R7 R8 R9 full sweep
        sweep(1'b0);

        // R10 same-cycle response: mask ch0, pol 1, pin source, OR
        wr(10'h223, 8'h01);
        wr(10'h224, 8'h01);
        wr(10'h225, 8'h00);
        #1;
        pio_pin = 2'b01;
        #0.3;
        check("R10 rise same cycle", {7'b0, respond}, 8'h01);
        pio_pin = 2'b00;
        #0.3;
        check("R10 fall same cycle", {7'b0, respond}, 8'h00);

        // R1 reset restores porl
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd_check("R1 ctrl after second reset", 10'h225, 8'h88);
        rd_check("R1 mask after second reset", 10'h223, 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule